// File: doc/BRIEF.md
# Scrolling Square-Wave Trace Generator

This block paints an oscilloscope strip for a raster display with no frame store. For every pixel position it computes a phase from the horizontal coordinate, measured from the left edge of the strip, plus a time offset drawn from a per-frame counter. One bit of that phase forms a square wave. Because the offset grows each frame, the wave appears to slide across the strip. The upper bits of the frame counter choose which phase bit is used, so the wave period keeps changing over time.

Two traces are drawn:

- The first trace shows the wave itself.
- The second trace shows its logical inverse.

Each trace is a thin line that sits on one row when the level is 1 and on a lower row when the level is 0. Where the level changes between neighbouring columns, a vertical stroke joins the two rows.

The block also exports the wave level at one fixed column. Other display layers use it as the shared "current input" state. The raster position comes in on `hpos`/`vpos`. The strip rectangle is given on four bound inputs. The per-pixel hit flags are combinational in the raster position, and the frame counter is registered.

Top module: `wavetrace_gen`

## Requirements
- R1: A 12-bit frame counter is cleared by a synchronous active-low reset. It increments by one at a clock edge where `hpos`==0 and `vpos`==0, holds at every other edge, and wraps modulo 4096.
- R2: The phase of column x is (x − `win_x0` + 4·frame[7:0]) modulo 1024.
- R3: The wave level at column x is one bit of that phase, chosen by code c = frame[10:8]. Codes 0,1,2,3 select bits 4,5,6,7, and codes 4,5,6,7 select bits 7,6,5,4. Frame bit 11 has no effect.
- R4: The input trace hits on row `win_y0`+10 when the wave level is 1, and on row `win_y0`+30 when it is 0.
- R5: For x > `win_x0`, if the level at x differs from the level at x−1, each trace also hits on every row from its high row to its low row inclusive. At x = `win_x0` no vertical stroke is drawn.
- R6: The output trace draws the inverse level using the same rules as the input trace, on rows `win_y0`+45 (level 1) and `win_y0`+65 (level 0).
- R7: Both hit flags are 0 outside the rectangle `win_x0`..`win_x1` × `win_y0`..`win_y1` (inclusive). They are also 0 where `hpos` ≥ 640 or `vpos` ≥ 480.
- R8: `logic_state` equals the wave level of R3 evaluated at absolute column 320, whatever the raster position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hpos | input | 10 | Current raster column |
| vpos | input | 10 | Current raster row |
| win_x0 | input | 10 | Left column of the strip (phase origin) |
| win_x1 | input | 10 | Right column of the strip, inclusive |
| win_y0 | input | 10 | Top row of the strip; trace rows are offsets from it |
| win_y1 | input | 10 | Bottom row of the strip, inclusive |
| in_hit | output | 1 | Pixel lies on the input trace |
| out_hit | output | 1 | Pixel lies on the inverted output trace |
| logic_state | output | 1 | Wave level at the reference column |

## Verification
A coarse grid sweep samples every trace row and the rows just outside the strip. It is repeated at frame values that hit each selector code, a wrap of the 8-bit offset and a set frame bit 11. This separates a wrong bit-selection table or a wrong offset scale from a wrong row mapping. Full column sweeps on rows lying strictly between a trace's high and low rows show only the vertical strokes, which isolates edge detection and the first-column rule. Moving the strip across the 640/480 visible limits checks that the visibility gate is separate from the window gate. Probes at the reference column, and after long stretches away from the origin, show that the exported state follows the frame counter and nothing else.

// File: rtl/wtg_pkg.sv
package wtg_pkg;

   typedef enum logic {
      POL_TRUE = 1'b0,
      POL_INV  = 1'b1
   } trace_pol_e;

   localparam int unsigned SEL_CODE_W = 3;
   localparam int unsigned SEL_IDX_W  = 2;
   localparam int unsigned SEL_TAPS   = 4;

   // Code to tap index: rising through the four taps, then falling back.
   function automatic logic [SEL_IDX_W-1:0] sel_index(input logic [SEL_CODE_W-1:0] code);
      return code[SEL_CODE_W-1] ? ~code[SEL_IDX_W-1:0] : code[SEL_IDX_W-1:0];
   endfunction

endpackage

// File: rtl/wtg_frame_ctr.sv
module wtg_frame_ctr #(
   parameter int unsigned FRAME_W = 12,
   parameter int unsigned X_W     = 10,
   parameter int unsigned Y_W     = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [X_W-1:0]     hpos,
   input  logic [Y_W-1:0]     vpos,
   output logic [FRAME_W-1:0] frame_q
);

   generate
      if (FRAME_W < 11) begin : g_bad_frame_w
         $error("wtg_frame_ctr: FRAME_W must cover the selector bits");
      end
   endgenerate

   logic at_origin;
   assign at_origin = (hpos == '0) && (vpos == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else if (at_origin) begin
         frame_q <= frame_q + 1'b1;
      end
   end

   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !at_origin |=> frame_q == $past(frame_q)); // R1
   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n) at_origin |=> frame_q == $past(frame_q) + 1'b1); // R1

endmodule

// File: rtl/wtg_phase_bit.sv
module wtg_phase_bit #(
   parameter int unsigned X_W     = 10,
   parameter int unsigned FRAME_W = 12,
   parameter int unsigned PH_W    = 10,
   parameter int unsigned OFS_W   = 8,
   parameter int unsigned SHIFT   = 2,
   parameter int unsigned LO_BIT  = 4
) (
   input  logic [X_W-1:0]     x,
   input  logic [X_W-1:0]     x_start,
   input  logic [FRAME_W-1:0] frame,
   output logic               wave
);
   import wtg_pkg::*;

   localparam int unsigned TOP_TAP  = LO_BIT + SEL_TAPS - 1;
   localparam int unsigned CODE_LSB = OFS_W;
   localparam int unsigned CODE_MSB = OFS_W + SEL_CODE_W - 1;

   generate
      if (TOP_TAP >= PH_W) begin : g_bad_tap
         $error("wtg_phase_bit: selected taps exceed the phase width");
      end
      if (CODE_MSB >= FRAME_W) begin : g_bad_code
         $error("wtg_phase_bit: selector code lies outside the frame counter");
      end
      if (OFS_W + SHIFT > PH_W) begin : g_bad_shift
         $error("wtg_phase_bit: scaled offset wider than the phase");
      end
   endgenerate

   logic [PH_W-1:0]       x_rel;
   logic [PH_W-1:0]       t_ofs;
   logic [PH_W-1:0]       phase;
   logic [SEL_TAPS-1:0]   cand;
   logic [SEL_IDX_W-1:0]  idx;

   assign x_rel = PH_W'(x - x_start);
   assign t_ofs = PH_W'({frame[OFS_W-1:0], {SHIFT{1'b0}}});
   assign phase = x_rel + t_ofs;
   assign idx   = sel_index(frame[CODE_MSB:CODE_LSB]);

   for (genvar i = 0; i < int'(SEL_TAPS); i++) begin : g_tap
      assign cand[i] = phase[LO_BIT + i];
   end

   assign wave = cand[idx];

endmodule

// File: rtl/wtg_trace.sv
module wtg_trace #(
   parameter int unsigned          Y_W     = 10,
   parameter int unsigned          HI_OFS  = 10,
   parameter int unsigned          LO_OFS  = 30,
   parameter wtg_pkg::trace_pol_e  POL     = wtg_pkg::POL_TRUE,
   parameter bit                   EDGE_EN = 1'b1
) (
   input  logic [Y_W-1:0] vpos,
   input  logic [Y_W-1:0] y_start,
   input  logic           wave_cur,
   input  logic           wave_prev,
   input  logic           has_prev,
   input  logic           window_ok,
   output logic           hit
);
   localparam int unsigned RW = Y_W + 1;

   generate
      if (HI_OFS >= LO_OFS) begin : g_bad_rows
         $error("wtg_trace: the level-1 row must lie above the level-0 row");
      end
      if (LO_OFS >= (1 << Y_W)) begin : g_bad_ofs
         $error("wtg_trace: row offset too large for the row width");
      end
   endgenerate

   logic [RW-1:0] y_ext, row_hi, row_lo;
   logic          lvl_cur, lvl_prev;
   logic          on_level, on_edge;

   assign y_ext  = RW'(vpos);
   assign row_hi = RW'(y_start) + RW'(HI_OFS);
   assign row_lo = RW'(y_start) + RW'(LO_OFS);

   generate
      if (POL == wtg_pkg::POL_INV) begin : g_inv
         assign lvl_cur  = ~wave_cur;
         assign lvl_prev = ~wave_prev;
      end else begin : g_true
         assign lvl_cur  = wave_cur;
         assign lvl_prev = wave_prev;
      end
   endgenerate

   assign on_level = (lvl_cur && (y_ext == row_hi)) || (!lvl_cur && (y_ext == row_lo));

   generate
      if (EDGE_EN) begin : g_edge
         assign on_edge = has_prev && (lvl_cur != lvl_prev) && (y_ext >= row_hi) && (y_ext <= row_lo);
      end else begin : g_no_edge
         assign on_edge = 1'b0;
      end
   endgenerate

   assign hit = window_ok && (on_level || on_edge);

endmodule

// File: rtl/wavetrace_gen.sv
module wavetrace_gen #(
   parameter int unsigned X_W        = 10,
   parameter int unsigned Y_W        = 10,
   parameter int unsigned H_VIS      = 640,
   parameter int unsigned V_VIS      = 480,
   parameter int unsigned FRAME_W    = 12,
   parameter int unsigned PH_W       = 10,
   parameter int unsigned OFS_W      = 8,
   parameter int unsigned SHIFT      = 2,
   parameter int unsigned LO_BIT     = 4,
   parameter int unsigned IN_HI_OFS  = 10,
   parameter int unsigned IN_LO_OFS  = 30,
   parameter int unsigned OUT_HI_OFS = 45,
   parameter int unsigned OUT_LO_OFS = 65,
   parameter int unsigned REF_X      = 320,
   parameter bit          EDGE_EN    = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [X_W-1:0] hpos,
   input  logic [Y_W-1:0] vpos,
   input  logic [X_W-1:0] win_x0,
   input  logic [X_W-1:0] win_x1,
   input  logic [Y_W-1:0] win_y0,
   input  logic [Y_W-1:0] win_y1,
   output logic           in_hit,
   output logic           out_hit,
   output logic           logic_state
);
   import wtg_pkg::*;

   localparam int unsigned N_TAPS   = 3;
   localparam int unsigned TAP_CUR  = 0;
   localparam int unsigned TAP_PREV = 1;
   localparam int unsigned TAP_REF  = 2;
   localparam int unsigned N_TRACE  = 2;
   localparam int unsigned RW       = Y_W + 1;

   generate
      if (H_VIS > (1 << X_W)) begin : g_bad_h
         $error("wavetrace_gen: visible width exceeds column range");
      end
      if (V_VIS > (1 << Y_W)) begin : g_bad_v
         $error("wavetrace_gen: visible height exceeds row range");
      end
      if (REF_X >= H_VIS) begin : g_bad_ref
         $error("wavetrace_gen: reference column must be visible");
      end
   endgenerate

   logic [FRAME_W-1:0] frame;
   logic [X_W-1:0]     tap_x [N_TAPS];
   logic [N_TAPS-1:0]  wave_tap;
   logic [N_TRACE-1:0] hit_vec;
   logic               window_ok, has_prev;
   logic [RW-1:0]      row_in_hi;

   wtg_frame_ctr #(.FRAME_W(FRAME_W), .X_W(X_W), .Y_W(Y_W)) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .hpos   (hpos),
      .vpos   (vpos),
      .frame_q(frame)
   );

   assign tap_x[TAP_CUR]  = hpos;
   assign tap_x[TAP_PREV] = hpos - 1'b1;
   assign tap_x[TAP_REF]  = X_W'(REF_X);

   for (genvar t = 0; t < int'(N_TAPS); t++) begin : g_phase
      wtg_phase_bit #(
         .X_W(X_W), .FRAME_W(FRAME_W), .PH_W(PH_W),
         .OFS_W(OFS_W), .SHIFT(SHIFT), .LO_BIT(LO_BIT)
      ) u_ph (
         .x      (tap_x[t]),
         .x_start(win_x0),
         .frame  (frame),
         .wave   (wave_tap[t])
      );
   end

   assign window_ok = (hpos < X_W'(H_VIS)) && (vpos < Y_W'(V_VIS)) &&
                      (hpos >= win_x0) && (hpos <= win_x1) &&
                      (vpos >= win_y0) && (vpos <= win_y1);
   assign has_prev  = hpos > win_x0;

   for (genvar k = 0; k < int'(N_TRACE); k++) begin : g_trace
      localparam int unsigned HI = (k == 0) ? IN_HI_OFS : OUT_HI_OFS;
      localparam int unsigned LO = (k == 0) ? IN_LO_OFS : OUT_LO_OFS;
      localparam trace_pol_e  PL = (k == 0) ? POL_TRUE : POL_INV;
      wtg_trace #(
         .Y_W(Y_W), .HI_OFS(HI), .LO_OFS(LO), .POL(PL), .EDGE_EN(EDGE_EN)
      ) u_tr (
         .vpos     (vpos),
         .y_start  (win_y0),
         .wave_cur (wave_tap[TAP_CUR]),
         .wave_prev(wave_tap[TAP_PREV]),
         .has_prev (has_prev),
         .window_ok(window_ok),
         .hit      (hit_vec[k])
      );
   end

   assign in_hit      = hit_vec[0];
   assign out_hit     = hit_vec[1];
   assign logic_state = wave_tap[TAP_REF];

   assign row_in_hi = RW'(win_y0) + RW'(IN_HI_OFS);

   AST_NO_STRAY_HIT: assert property (@(posedge clk) disable iff (!rst_n) !window_ok |-> (!in_hit && !out_hit)); // R7
   AST_REF_ROW_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (hpos == X_W'(REF_X) && window_ok && RW'(vpos) == row_in_hi && wave_tap[TAP_CUR] == wave_tap[TAP_PREV]) |-> (in_hit == logic_state)); // R8
   AST_STATE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n) (!$stable(logic_state) && $stable(win_x0)) |-> $past(hpos == '0 && vpos == '0)); // R1

endmodule

// File: tb/wavetrace_gen_tb_top.sv
module wavetrace_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int X0 = 100;
   localparam int REFX = 320;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] hpos = '0, vpos = '0;
   logic [9:0] win_x0 = 10'(X0), win_x1 = 10'd539, win_y0 = 10'd380, win_y1 = 10'd460;
   logic       in_hit, out_hit, logic_state;

   int  checks = 0, failures = 0, mframe = 0;
   bit  done = 1'b0;
   logic [2:0] exp_q [$];
   string      tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   wavetrace_gen dut_i (
      .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
      .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
      .in_hit(in_hit), .out_hit(out_hit), .logic_state(logic_state)
   );

   function automatic int mwave(int x);
      int code, b, ph;
      code = (mframe >> 8) & 7;
      b    = (code < 4) ? 4 + code : 11 - code;
      ph   = (x - int'(win_x0) + (mframe & 255) * 4) & 1023;
      return (ph >> b) & 1;
   endfunction

   function automatic bit mhit(int x, int y, int hi_o, int lo_o, bit inv);
      int w, wp, hi, lo;
      bit inreg, edg;
      inreg = x >= int'(win_x0) && x <= int'(win_x1) && y >= int'(win_y0) &&
              y <= int'(win_y1) && x < 640 && y < 480;
      w  = mwave(x);
      wp = (x > int'(win_x0)) ? mwave(x - 1) : w;
      edg = (w != wp);
      if (inv) w = 1 - w;
      hi = int'(win_y0) + hi_o;
      lo = int'(win_y0) + lo_o;
      return inreg && ((w == 1 && y == hi) || (w == 0 && y == lo) || (edg && y >= hi && y <= lo));
   endfunction

   // driver: applies one position and pushes the expected result
   task automatic probe(int x, int y, string tag);
      @(posedge clk);
      #1;
      hpos = 10'(x);
      vpos = 10'(y);
      exp_q.push_back({mhit(x, y, 10, 30, 1'b0), mhit(x, y, 45, 65, 1'b1), mwave(REFX) == 1});
      tag_q.push_back(tag);
   endtask

   task automatic advance(int n);
      @(posedge clk);
      #1;
      hpos = '0;
      vpos = '0;
      repeat (n) @(posedge clk);
      #1;
      hpos = 10'd5;
      vpos = 10'd5;
      mframe = (mframe + n) & 4095;
   endtask

   // monitor: compares away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({in_hit, out_hit, logic_state} !== e) begin
            failures++;
            $display("FAIL %s x=%0d y=%0d frame=%0d got in/out/state=%b expected=%b",
                     t, hpos, vpos, mframe, {in_hit, out_hit, logic_state}, e);
         end
      end
   end

   task automatic grid();
      int rows [8];
      rows = '{379, 390, 400, 410, 425, 435, 445, 461};
      for (int x = 97; x <= 543; x += 7)
         for (int r = 0; r < 8; r++) probe(x, rows[r], "R2 R3 R4 R6");
   endtask

   task automatic edge_sweep();
      for (int x = X0; x <= 539; x++) begin
         probe(x, 400, "R5");
         if (x % 3 == 0) probe(x, 435, "R5");
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int stages [13];
      stages = '{1, 6, 56, 193, 256, 256, 256, 256, 256, 256, 256, 2, 300};
      repeat (4) @(posedge clk);
      #1;
      hpos = 10'd5; vpos = 10'd5;
      rst_n = 1'b1;
      // reset state: frame 0
      probe(REFX, 390, "R1 R8");
      probe(X0, 410, "R1 R4");
      grid();
      edge_sweep();
      for (int s = 0; s < 13; s++) begin
         advance(stages[s]);
         for (int k = 0; k < 4; k++) probe(REFX, 390 + k, "R8");
         grid();
         if (s % 2 == 0) edge_sweep();
      end
      // long hold away from the origin must not step the counter
      repeat (40) probe(600, 10, "R1");
      advance(1);
      probe(REFX, 10, "R1 R8");
      // visibility limits
      win_x1 = 10'd700; win_y1 = 10'd600;
      for (int x = 630; x < 660; x++) begin
         probe(x, 390, "R7");
         probe(x, 410, "R7");
         probe(x, 445, "R7");
      end
      win_y0 = 10'd460;
      for (int x = 200; x < 260; x++) begin
         probe(x, 470, "R7");
         probe(x, 490, "R7");
         probe(x, 505, "R7");
      end
      win_x1 = 10'd539; win_y1 = 10'd460; win_y0 = 10'd380;
      probe(99, 390, "R7");
      probe(540, 410, "R7");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule